// File: doc/BRIEF.md
# Signed Divider with Status Flags

This unit sits in the execute stage of a small processor and divides a signed 32-bit dividend by a signed divisor. The divisor is either a full word or, in halfword mode, the low 16 bits of the divisor input sign-extended to 32 bits. The quotient is rounded toward zero. The unit divides the two magnitudes and then applies the sign. It reports a destination write strobe with the quotient, plus zero, sign and overflow flags, each with its own update enable.

A normal divide runs a restoring shift-subtract loop that produces one quotient bit per cycle, followed by a single finalize cycle. Two operand patterns are caught before the loop starts and finish in one cycle. The first is a zero divisor. The second is the most negative dividend divided by minus one, whose true quotient cannot be represented. Each of these two cases has its own rule for the destination write and the flag updates. A new start is accepted in any cycle where busy is low, including the cycle in which the previous result is delivered.

Top module: `sdiv_unit`

## Requirements
- R1: After reset, busy, done, destWe, flagZWe, flagSWe and flagOvWe are all 0, and quotOut, flagZ, flagS and flagOv are 0.
- R2: For a normal divide, quotOut equals the signed quotient truncated toward zero, for every combination of operand signs.
- R3: On completion of a normal divide, destWe, flagZWe, flagSWe and flagOvWe are 1; flagZ is 1 exactly when the quotient is 0; flagS equals quotient bit 31; flagOv is 0.
- R4: When halfMode is 1, the effective divisor is divisorIn[15:0] sign-extended to 32 bits, and divisorIn[31:16] has no effect.
- R5: When the dividend is 32'h8000_0000 and the effective divisor is 32'hFFFF_FFFF, the unit completes with quotOut = 32'h8000_0000, destWe = 1, all three flag enables = 1, flagOv = 1, flagS = 1 and flagZ = 0.
- R6: When the effective divisor is 0, the unit completes with flagOvWe = 1 and flagOv = 1, while destWe, flagZWe and flagSWe are 0, and quotOut, flagZ and flagS keep their previous values.
- R7: A normal divide raises busy in the cycle after start is sampled and holds it high for exactly 33 cycles. done is high for one cycle, in the first cycle with busy low.
- R8: The R5 and R6 cases never raise busy. They assert done in the cycle right after start is sampled.
- R9: start is ignored while busy is high: the running divide keeps its timing and its result.
- R10: destWe, flagZWe, flagSWe and flagOvWe are 0 in every cycle in which done is 0.
- R11: start asserted in the cycle where done is high is accepted, and that operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; sampled only while busy is low |
| halfMode | input | 1 | 1: divisor is divisorIn[15:0] sign-extended |
| dividendIn | input | 32 | Signed dividend |
| divisorIn | input | 32 | Signed divisor (word or low halfword) |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle completion pulse |
| quotOut | output | 32 | Quotient, valid when destWe is high |
| destWe | output | 1 | Destination register write enable |
| flagZ | output | 1 | Zero flag value |
| flagS | output | 1 | Sign flag value |
| flagOv | output | 1 | Overflow flag value |
| flagZWe | output | 1 | Zero flag update enable |
| flagSWe | output | 1 | Sign flag update enable |
| flagOvWe | output | 1 | Overflow flag update enable |

## Verification
Two functions can coincide. One is the result delivery of one divide; the other is the acceptance of the next start, which may be a one-cycle special case. The driver raises the next start at the very negative edge on which the previous done is visible. Ops are chained so that a normal divide is followed directly by a zero-divisor case and by an overflow case. The scoreboard then checks that each done pulse lands on the cycle predicted for its own operation. It also checks that each carries its own write and flag pattern, and that the zero-divisor case leaves quotOut and the Z and S flags exactly where the preceding result put them.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef struct packed {
    logic load;      // latch magnitudes, begin iteration
    logic step;      // one restoring shift-subtract step
    logic fin;       // apply sign, publish result and flags
    logic zeroCase;  // divisor zero: overflow only
    logic ovfCase;   // most-negative / -1
  } divStrobe_t;
endpackage

// File: rtl/sdiv_path.sv
module sdiv_path
  import sdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobe_t   strb,
  input  logic         halfMode,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic         isZero,
  output logic         isOvf,
  output logic [W-1:0] quotOut,
  output logic         destWe,
  output logic         flagZ,
  output logic         flagS,
  output logic         flagOv,
  output logic         flagZWe,
  output logic         flagSWe,
  output logic         flagOvWe
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] effDvs, aMag, bMag, qFinal;
  logic [W-1:0] remR, quoR, dvsR;
  logic         negR;
  logic [W:0]   shifted, diff;
  logic         fits;

  always_comb begin
    effDvs  = halfMode ? {{(W-HW){divisorIn[HW-1]}}, divisorIn[HW-1:0]} : divisorIn;
    isZero  = (effDvs == '0);
    isOvf   = (dividendIn == MOST_NEG) && (effDvs == '1);
    aMag    = dividendIn[W-1] ? (~dividendIn + 1'b1) : dividendIn;
    bMag    = effDvs[W-1] ? (~effDvs + 1'b1) : effDvs;
    shifted = {remR, quoR[W-1]};
    diff    = shifted - {1'b0, dvsR};
    fits    = (shifted >= {1'b0, dvsR});
    qFinal  = negR ? (~quoR + 1'b1) : quoR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      dvsR <= '0;
      negR <= 1'b0;
    end else if (strb.load) begin
      remR <= '0;
      quoR <= aMag;
      dvsR <= bMag;
      negR <= dividendIn[W-1] ^ effDvs[W-1];
    end else if (strb.step) begin
      remR <= fits ? diff[W-1:0] : shifted[W-1:0];
      quoR <= {quoR[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotOut  <= '0;
      flagZ    <= 1'b0;
      flagS    <= 1'b0;
      flagOv   <= 1'b0;
      destWe   <= 1'b0;
      flagZWe  <= 1'b0;
      flagSWe  <= 1'b0;
      flagOvWe <= 1'b0;
    end else begin
      destWe   <= strb.fin | strb.ovfCase;
      flagZWe  <= strb.fin | strb.ovfCase;
      flagSWe  <= strb.fin | strb.ovfCase;
      flagOvWe <= strb.fin | strb.ovfCase | strb.zeroCase;
      if (strb.fin) begin
        quotOut <= qFinal;
        flagZ   <= (qFinal == '0);
        flagS   <= qFinal[W-1];
        flagOv  <= 1'b0;
      end else if (strb.ovfCase) begin
        quotOut <= MOST_NEG;
        flagZ   <= 1'b0;
        flagS   <= 1'b1;
        flagOv  <= 1'b1;
      end else if (strb.zeroCase) begin
        flagOv  <= 1'b1;
      end
    end
  end

  // R5
  ovf_case_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ovfCase |=> (quotOut == MOST_NEG) && destWe && flagOv && flagS && !flagZ);
  // R6
  zero_case_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroCase |=> $stable(quotOut) && $stable(flagZ) && $stable(flagS)
                      && flagOv && flagOvWe && !destWe && !flagZWe && !flagSWe);
  // R3
  fin_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fin |=> destWe && flagZWe && flagSWe && !flagOv
                 && (flagZ == (quotOut == '0)) && (flagS == quotOut[W-1]));
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isZero,
  input  logic       isOvf,
  output divStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_FIN } divState_t;
  divState_t state;
  logic [CW-1:0] bitCnt;

  always_comb begin
    busy          = (state != ST_IDLE);
    strb          = '0;
    strb.zeroCase = (state == ST_IDLE) && start && isZero;
    strb.ovfCase  = (state == ST_IDLE) && start && !isZero && isOvf;
    strb.load     = (state == ST_IDLE) && start && !isZero && !isOvf;
    strb.step     = (state == ST_RUN);
    strb.fin      = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.fin | strb.zeroCase | strb.ovfCase;
      case (state)
        ST_IDLE: if (strb.load) begin
          state  <= ST_RUN;
          bitCnt <= '0;
        end
        ST_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [CW+1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= busy ? runLen + 1'b1 : '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == (CW+2)'(W + 1)));
  // R7 R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         halfMode,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotOut,
  output logic         destWe,
  output logic         flagZ,
  output logic         flagS,
  output logic         flagOv,
  output logic         flagZWe,
  output logic         flagSWe,
  output logic         flagOvWe
);
  divStrobe_t strb;
  logic       isZero, isOvf;

  sdiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isZero(isZero), .isOvf(isOvf),
    .strb(strb), .busy(busy), .done(done)
  );

  sdiv_path #(.W(W), .HW(HW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .halfMode(halfMode),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .isZero(isZero), .isOvf(isOvf), .quotOut(quotOut), .destWe(destWe),
    .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv),
    .flagZWe(flagZWe), .flagSWe(flagSWe), .flagOvWe(flagOvWe)
  );

  // R10
  we_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (destWe | flagZWe | flagSWe | flagOvWe) |-> done);
endmodule

// File: tb/sdiv_unit_tb.sv
`timescale 1ns/1ps
module sdiv_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        halfMode = 1'b0;
  logic [31:0] dividendIn = '0;
  logic [31:0] divisorIn = '0;
  logic        busy, done, destWe, flagZ, flagS, flagOv, flagZWe, flagSWe, flagOvWe;
  logic [31:0] quotOut;

  sdiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .halfMode(halfMode),
    .dividendIn(dividendIn), .divisorIn(divisorIn), .busy(busy), .done(done),
    .quotOut(quotOut), .destWe(destWe), .flagZ(flagZ), .flagS(flagS),
    .flagOv(flagOv), .flagZWe(flagZWe), .flagSWe(flagSWe), .flagOvWe(flagOvWe)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] q;
    logic        z, s, ov, we, zWe, sWe, ovWe;
    int          due;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  logic [31:0] lastQ = '0;
  logic        lastZ = 1'b0, lastS = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        if (sbQ.size() == 0) check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
        else begin
          expItem_t e;
          e = sbQ.pop_front();
          check(cyc == e.due, {e.tag, " done cycle"}, 32'(cyc), 32'(e.due));
          check(quotOut == e.q, {e.tag, " quotient"}, quotOut, e.q);
          check({destWe, flagZWe, flagSWe, flagOvWe} == {e.we, e.zWe, e.sWe, e.ovWe},
                {e.tag, " enables"}, 32'({destWe, flagZWe, flagSWe, flagOvWe}),
                32'({e.we, e.zWe, e.sWe, e.ovWe}));
          check({flagZ, flagS, flagOv} == {e.z, e.s, e.ov}, {e.tag, " flags"},
                32'({flagZ, flagS, flagOv}), 32'({e.z, e.s, e.ov}));
        end
      end else begin
        check({destWe, flagZWe, flagSWe, flagOvWe} == 4'b0, "R10 enables idle",
              32'({destWe, flagZWe, flagSWe, flagOvWe}), 32'd0);
      end
    end
  end

  // driver: called at a negedge where busy is low
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic hm,
                       input logic junk, input string tag);
    expItem_t e;
    logic [31:0] eb;
    logic signed [31:0] sa, sb, sq;
    logic special;
    int nb;
    eb = hm ? {{16{b[15]}}, b[15:0]} : b;
    e.tag = tag;
    if (eb == 32'd0) begin
      special = 1'b1;
      e.q = lastQ; e.z = lastZ; e.s = lastS; e.ov = 1'b1;
      e.we = 1'b0; e.zWe = 1'b0; e.sWe = 1'b0; e.ovWe = 1'b1;
    end else if (a == 32'h8000_0000 && eb == 32'hFFFF_FFFF) begin
      special = 1'b1;
      e.q = 32'h8000_0000; e.z = 1'b0; e.s = 1'b1; e.ov = 1'b1;
      e.we = 1'b1; e.zWe = 1'b1; e.sWe = 1'b1; e.ovWe = 1'b1;
    end else begin
      special = 1'b0;
      sa = a; sb = eb; sq = sa / sb;
      e.q = sq; e.z = (sq == 0); e.s = sq[31]; e.ov = 1'b0;
      e.we = 1'b1; e.zWe = 1'b1; e.sWe = 1'b1; e.ovWe = 1'b1;
    end
    e.due = cyc + (special ? 1 : 34);
    if (e.we) lastQ = e.q;
    if (e.zWe) lastZ = e.z;
    if (e.sWe) lastS = e.s;
    sbQ.push_back(e);
    dividendIn = a; divisorIn = b; halfMode = hm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (cyc < e.due) begin
      if (busy) nb++;
      if (junk && cyc == e.due - 20) begin
        start = 1'b1; dividendIn = 32'h0000_DEAD; divisorIn = 32'd0; halfMode = 1'b0;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(nb == (special ? 0 : 33), special ? "R8 busy cycles" : "R7 busy cycles",
          32'(nb), special ? 32'd0 : 32'd33);
    check(!busy, "R7 busy low at done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, destWe, flagZWe, flagSWe, flagOvWe} == 6'b0, "R1 reset outputs",
          32'({busy, done, destWe, flagZWe, flagSWe, flagOvWe}), 32'd0);
    check({quotOut, flagZ, flagS, flagOv} == 35'b0, "R1 reset values", quotOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    issue(32'd100, 32'd7, 1'b0, 1'b0, "R2 R3 pos/pos");
    issue(-32'sd100, 32'd7, 1'b0, 1'b0, "R2 R3 neg/pos");      // back-to-back: R11
    issue(32'd100, -32'sd7, 1'b0, 1'b0, "R2 neg divisor");
    issue(-32'sd100, -32'sd7, 1'b0, 1'b0, "R2 neg/neg");
    issue(32'd3, 32'd5, 1'b0, 1'b0, "R3 zero quotient");
    issue(-32'sd7, 32'd2, 1'b0, 1'b0, "R2 truncation");
    issue(32'd5, 32'd0, 1'b0, 1'b0, "R6 R11 zero divisor after done");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 R8 word overflow");
    repeat (3) @(negedge clk);
    issue(32'h8000_0000, 32'd2, 1'b0, 1'b0, "R2 most negative /2");
    issue(32'h8000_0000, 32'd1, 1'b0, 1'b0, "R2 most negative /1");
    issue(32'd50, 32'hABCD_FFF9, 1'b1, 1'b0, "R4 half sext -7");
    issue(32'h7FFF_FFFF, 32'h0000_8000, 1'b1, 1'b0, "R4 half -32768");
    issue(32'h8000_0000, 32'h1234_FFFF, 1'b1, 1'b0, "R4 R5 half overflow");
    issue(32'd9, 32'hFFFF_0000, 1'b1, 1'b0, "R4 R6 half zero");
    issue(32'd1000, 32'd9, 1'b0, 1'b1, "R9 start while busy");
    issue(32'd77, 32'd0, 1'b0, 1'b0, "R6 hold after R9");
    repeat (4) @(negedge clk);
    check(sbQ.size() == 0, "R7 scoreboard drained", 32'(sbQ.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule